// File: doc/BRIEF.md
# Three-Axis Bidirectional Click Detector

This block watches three signed acceleration streams (X, Y, Z) and flags "click" gestures. A click is a two-crossing event on one axis. The sample first moves beyond a programmable magnitude threshold, and a later sample comes back inside it. The event is declared on the sample that comes back. Excursions on the positive and the negative side are told apart, so each axis has two sticky direction flags.

Any set flag drives a level interrupt and a combined click bit in an 8-bit status byte. Software reads that byte and pulses a read strobe, and the strobe clears every flag at once. Samples are taken only on a valid strobe. Each axis can be enabled on its own, and one 4-bit code sets the threshold for all axes.

Top module: `click_detector`

## Requirements
- R1: Each axis has its own enable (`axis_en_i` bit 0 = X, bit 1 = Y, bit 2 = Z). A disabled axis never sets a flag, whatever samples arrive.
- R2: The threshold in LSB is the 4-bit code times 64 (code 8 gives 512, code 1 gives 64, code 12 gives 768). A sample counts as beyond only when its magnitude is strictly greater than the threshold: a sample equal to +threshold or −threshold is not beyond it.
- R3: A strobed sample above +threshold, followed by a strobed sample at or below +threshold, sets the axis positive flag. An excursion that has not yet returned sets nothing.
- R4: A strobed sample below −threshold, followed by a strobed sample at or above −threshold, sets the axis negative flag.
- R5: `status_o` is laid out as follows. Bit 7 is 0. Bit 6 is the combined click flag, the OR of bits 5..0. Bits 5..0 are X+, X−, Y+, Y−, Z+, Z−. A flag is visible from the clock edge that takes the return sample.
- R6: The flags and `click_irq_o` stay high until a cycle with `status_rd_i` high. All of them are low after that edge.
- R7: An event detected in the same cycle as `status_rd_i` is still set after the clear. Flags that were set before that cycle are cleared.
- R8: The axis state advances only in cycles with `sample_vld_i` high. Samples without the strobe are ignored.
- R9: Clearing an axis enable abandons any pending excursion on that axis. After the axis is enabled again, a return sample alone does not fire an event.
- R10: A sample that swings from above +threshold straight to below −threshold fires the positive event. It also arms a negative excursion, which fires on the next sample at or above −threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | Marks a new sample triple on the acceleration inputs |
| acc_x_i | input | 11 | X acceleration, two's complement |
| acc_y_i | input | 11 | Y acceleration, two's complement |
| acc_z_i | input | 11 | Z acceleration, two's complement |
| axis_en_i | input | 3 | Per-axis enable: bit 0 = X, bit 1 = Y, bit 2 = Z |
| thr_code_i | input | 4 | Threshold code, 64 LSB per step |
| status_rd_i | input | 1 | Status read strobe; clears all flags |
| click_irq_o | output | 1 | Level interrupt, high while any flag is set |
| status_o | output | 8 | {0, combined, X+, X−, Y+, Y−, Z+, Z−} |

## Verification
Each axis holds its state in a small tracker. If a tracker is stuck in a wrong state, the error shows at the ports on the next strobed sample. Either a flag appears for a lone return sample, or an expected flag is missing after a complete excursion. Corrupt latch state shows up as wrong bits in `status_o` during the same cycle. A clear that leaks or fails is visible one edge after the read strobe. Off-by-one comparisons are caught only by samples placed exactly on the threshold, and the tests include such samples.

// File: rtl/click_pkg.sv
package click_pkg;
  parameter int DATA_W     = 11;
  parameter int CODE_W     = 4;
  parameter int STEP_SHIFT = 6;
  parameter int N_AXES     = 3;

  localparam int THR_W   = DATA_W + 1;
  localparam int N_FLAGS = 2 * N_AXES;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_ABOVE_POS = 2'd1,
    ST_BELOW_NEG = 2'd2
  } click_st_e;
endpackage

// File: rtl/click_axis.sv
module click_axis
  import click_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int TW = THR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [TW-1:0] thr_i,
  output logic                 ev_pos_o,
  output logic                 ev_neg_o,
  output logic [1:0]           st_o
);
  click_st_e st_q, st_d;
  logic signed [TW-1:0] smp_ext;
  logic over, under;

  assign smp_ext = {{(TW-DW){smp_i[DW-1]}}, smp_i};
  assign over    = smp_ext > thr_i;
  assign under   = smp_ext < -thr_i;

  always_comb begin
    st_d     = st_q;
    ev_pos_o = 1'b0;
    ev_neg_o = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else if (vld_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (over)       st_d = ST_ABOVE_POS;
          else if (under) st_d = ST_BELOW_NEG;
        end
        ST_ABOVE_POS: begin
          if (!over) begin
            ev_pos_o = 1'b1;
            st_d     = under ? ST_BELOW_NEG : ST_IDLE;
          end
        end
        ST_BELOW_NEG: begin
          if (!under) begin
            ev_neg_o = 1'b1;
            st_d     = over ? ST_ABOVE_POS : ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/click_latch.sv
module click_latch #(
  parameter int NF = click_pkg::N_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] ev_i,
  input  logic          clr_i,
  output logic [NF-1:0] flags_o
);
  logic [NF-1:0] flags_q;

  // same-cycle event wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clr_i ? '0 : flags_q) | ev_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/click_detector.sv
module click_detector
  import click_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_vld_i,
  input  logic signed [DATA_W-1:0] acc_x_i,
  input  logic signed [DATA_W-1:0] acc_y_i,
  input  logic signed [DATA_W-1:0] acc_z_i,
  input  logic [N_AXES-1:0]        axis_en_i,
  input  logic [CODE_W-1:0]        thr_code_i,
  input  logic                     status_rd_i,
  output logic                     click_irq_o,
  output logic [7:0]               status_o
);
  logic signed [DATA_W-1:0] acc_arr [N_AXES];
  logic signed [THR_W-1:0]  thr_w;
  logic [N_FLAGS-1:0]       ev_w;
  logic [N_FLAGS-1:0]       flags_w;
  logic [2*N_AXES-1:0]      st_all_w;

  assign acc_arr[0] = acc_x_i;
  assign acc_arr[1] = acc_y_i;
  assign acc_arr[2] = acc_z_i;

  assign thr_w = signed'(THR_W'(thr_code_i) << STEP_SHIFT);

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    click_axis u_axis (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (axis_en_i[a]),
      .vld_i    (sample_vld_i),
      .smp_i    (acc_arr[a]),
      .thr_i    (thr_w),
      .ev_pos_o (ev_w[2*(N_AXES-1-a)+1]),
      .ev_neg_o (ev_w[2*(N_AXES-1-a)]),
      .st_o     (st_all_w[2*a+1:2*a])
    );
  end

  click_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev_w),
    .clr_i   (status_rd_i),
    .flags_o (flags_w)
  );

  assign click_irq_o = |flags_w;
  assign status_o    = {1'b0, |flags_w, flags_w};
endmodule

// File: rtl/click_detector_chk.sv
module click_detector_chk
  import click_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sample_vld_i,
  input logic [N_AXES-1:0]    axis_en_i,
  input logic                 status_rd_i,
  input logic                 click_irq_o,
  input logic [7:0]           status_o,
  input logic [N_FLAGS-1:0]   ev_i,
  input logic [2*N_AXES-1:0]  st_i
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && ev_i == '0) |=> status_o[5:0] == '0); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_rd_i |=> ((status_o[5:0] & $past(status_o[5:0])) == $past(status_o[5:0]))); // R6

  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    click_irq_o == (status_o[5:0] != '0)); // R6

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && ev_i != '0) |=> ((status_o[5:0] & $past(ev_i)) == $past(ev_i))); // R7

  for (genvar a = 0; a < N_AXES; a++) begin : g_ax
    AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !axis_en_i[a] |-> ev_i[2*(N_AXES-1-a)+1 -: 2] == 2'b00); // R1

    AST_ONE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ev_i[2*(N_AXES-1-a)+1 -: 2])); // R10

    AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sample_vld_i && axis_en_i[a]) |=> $stable(st_i[2*a+1 -: 2])); // R8

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !axis_en_i[a] |=> st_i[2*a+1 -: 2] == 2'(ST_IDLE)); // R9
  end
endmodule

bind click_detector click_detector_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_vld_i (sample_vld_i),
  .axis_en_i    (axis_en_i),
  .status_rd_i  (status_rd_i),
  .click_irq_o  (click_irq_o),
  .status_o     (status_o),
  .ev_i         (ev_w),
  .st_i         (st_all_w)
);

// File: tb/click_detector_tb.sv
module click_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [10:0] ax = '0, ay = '0, az = '0;
  logic [2:0]  en = 3'b111;
  logic [3:0]  code = 4'd8;
  logic        rd = 1'b0;
  logic        irq;
  logic [7:0]  st;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  click_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld),
    .acc_x_i(ax), .acc_y_i(ay), .acc_z_i(az),
    .axis_en_i(en), .thr_code_i(code), .status_rd_i(rd),
    .click_irq_o(irq), .status_o(st)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic smp(input int x, input int y, input int z);
    @(negedge clk);
    ax = x[10:0]; ay = y[10:0]; az = z[10:0]; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R5 reset status", st, 8'h00);
    check("R6 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pos_x();
    smp(600, 0, 0);
    check("R3 pending excursion", st, 8'h00);
    smp(100, 0, 0);
    check("R3 X+ flag", st, 8'h60);
    check("R6 irq high", {7'd0, irq}, 8'h01);
    smp(0, 0, 0);
    check("R6 flag sticky", st, 8'h60);
    clr();
    check("R6 cleared", st, 8'h00);
    check("R6 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_neg_y();
    smp(0, -600, 0);
    smp(0, 0, 0);
    check("R4 Y- flag", st, 8'h44);
    clr();
  endtask

  task automatic t_boundary();
    smp(0, 0, 512);
    smp(0, 0, 0);
    check("R2 equal not beyond", st, 8'h00);
    smp(0, 0, -512);
    smp(0, 0, 0);
    check("R2 equal negative not beyond", st, 8'h00);
    smp(0, 0, 513);
    smp(0, 0, 512);
    check("R2 return at threshold fires Z+", st, 8'h42);
    clr();
  endtask

  task automatic t_codes();
    code = 4'd1;
    smp(65, 0, 0);
    smp(64, 0, 0);
    check("R2 code 1 fires", st, 8'h60);
    clr();
    code = 4'd12;
    smp(700, 0, 0);
    smp(0, 0, 0);
    check("R2 code 12 below thr", st, 8'h00);
    smp(769, 0, 0);
    smp(0, 0, 0);
    check("R2 code 12 fires", st, 8'h60);
    clr();
    code = 4'd8;
  endtask

  task automatic t_disable();
    en = 3'b011;
    smp(0, 0, 900);
    smp(0, 0, 0);
    smp(0, 0, -900);
    smp(0, 0, 0);
    check("R1 disabled Z silent", st, 8'h00);
    en = 3'b111;
  endtask

  task automatic t_mid_disable();
    smp(900, 0, 0);
    @(negedge clk); en = 3'b110;
    @(negedge clk); en = 3'b111;
    smp(0, 0, 0);
    check("R9 abandoned excursion", st, 8'h00);
  endtask

  task automatic t_strobe();
    @(negedge clk); ax = 11'd900;
    @(negedge clk); ax = 11'd0;
    @(negedge clk);
    smp(0, 0, 0);
    check("R8 unstrobed excursion ignored", st, 8'h00);
    smp(900, 0, 0);
    @(negedge clk); ax = 11'd0;
    @(negedge clk);
    check("R8 unstrobed return ignored", st, 8'h00);
    smp(0, 0, 0);
    check("R8 strobed return fires", st, 8'h60);
    clr();
  endtask

  task automatic t_swing();
    smp(900, 0, 0);
    smp(-900, 0, 0);
    check("R10 swing fires X+", st, 8'h60);
    smp(0, 0, 0);
    check("R10 then X-", st, 8'h70);
    clr();
  endtask

  task automatic t_multi();
    smp(900, 900, 900);
    smp(0, 0, 0);
    check("R5 three positive flags", st, 8'h6A);
    clr();
  endtask

  task automatic t_same_cycle();
    smp(0, 900, 0);
    smp(0, 0, 0);
    check("R7 preset Y+", st, 8'h48);
    smp(900, 0, 0);
    @(negedge clk);
    ax = 11'd0; vld = 1'b1; rd = 1'b1;
    @(negedge clk);
    vld = 1'b0; rd = 1'b0;
    check("R7 event survives clear", st, 8'h60);
    clr();
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_pos_x();
    t_neg_y();
    t_boundary();
    t_codes();
    t_disable();
    t_mid_disable();
    t_strobe();
    t_swing();
    t_multi();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule